// File: doc/BRIEF.md
# Static Memory Bus Controller with Per-Bank Timing

This block connects a 32-bit internal request channel to an external asynchronous static memory bus of the SRAM, ROM or NOR type. Every bank on the external side shares the address lines, the data lines and the strobes, and each bank has a chip select of its own. A request is accepted on a valid/ready handshake. It is then played out on the external bus as two 16-bit beats or four 8-bit beats, depending on the bus width configured for the addressed bank. A single response, carrying the assembled read word, is returned on a second valid/ready channel.

Each bank has two timing sets, one for reads and one for writes, and each set holds three 4-bit values. The strobe delay is the number of cycles the chip select is held low before the output-enable or write-enable strobe asserts. The wait count adds cycles to the strobe. The turnaround is the number of idle cycles the bus must see after the last beat. The controller picks the set that matches the direction of the access. Only one request is in progress at any time.

Back-pressure rules. `req_ready` is high only when the controller is idle with no response pending. A request is taken on the cycle where `req_valid` and `req_ready` are both high. `rsp_valid` stays high until `rsp_ready` is seen, and `rsp_rdata` does not change while it waits. No new request is taken while a response is pending or while a turnaround is still running.

Top module: `smc_bridge`

## Requirements
- R1: While reset is active and right after it, every `mem_cs_n` bit is 1, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0, and `req_ready` is 1 once reset is released.
- R2: Bits `req_addr[BANK_LSB+1:BANK_LSB]` (bits 25:24 by default) select the bank. Only that bank's `mem_cs_n` goes low, and at most one chip select is low in any cycle.
- R3: From an accepted request until its response has been taken and its turnaround has elapsed, `req_ready` stays 0, so requests never overlap.
- R4: In each beat the chip select is low with both strobes high for `dly` cycles, then the strobe is low for `wt`+1 cycles. Over one request the chip select is therefore low for beats×(`dly`+`wt`+1) cycles.
- R5: Timing config bits [12b+11:12b+8] hold `dly`, [12b+7:12b+4] hold `wt` and [12b+3:12b] hold `turn` for bank b. A read uses `cfg_rd_tim` and a write uses `cfg_wr_tim`.
- R6: After the last beat of a request, every chip select stays high for at least `turn` cycles before any chip select goes low again.
- R7: `cfg_bus16[b]`=1 gives a 16-bit bank with 2 beats at `mem_addr` = byte address>>1, then +1. `cfg_bus16[b]`=0 gives an 8-bit bank with 4 beats at the byte address, then +1, +2, +3. Beats run in ascending order and `req_addr[1:0]` is ignored.
- R8: For a write, beat k drives `wdata[16k+15:16k]` on a 16-bit bank, or `wdata[8k+7:8k]` on `mem_dq_o[7:0]` on an 8-bit bank, with `mem_dq_oe` high throughout the beat.
- R9: For a 16-bit write, `mem_bl_n` = ~`be[2k+1:2k]`. For an 8-bit write, `mem_bl_n[0]` = ~`be[k]`. Reads enable every lane. A beat with no enabled lane keeps `mem_we_n` high but still takes its full time.
- R10: Read data is sampled on the last strobe cycle of each beat and placed little-endian into the word: beat k goes to bits [16k+15:16k], or to [8k+7:8k] from `mem_dq_i[7:0]`. The upper byte of an 8-bit bank is ignored.
- R11: Exactly one response follows each request, after its final beat. It holds `rsp_valid` and a stable `rsp_rdata` until `rsp_ready`. `rsp_rdata` is 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; bank in bits 25:24 |
| req_wdata | input | 32 | Write word |
| req_be | input | 4 | Byte enables for writes |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with valid |
| rsp_rdata | output | 32 | Assembled read word (0 for writes) |
| cfg_rd_tim | input | NBANK*12 | Read timing per bank |
| cfg_wr_tim | input | NBANK*12 | Write timing per bank |
| cfg_bus16 | input | NBANK | 1 = 16-bit bank, 0 = 8-bit bank |
| mem_cs_n | output | NBANK | Chip selects, active low |
| mem_addr | output | AW | External address |
| mem_dq_o | output | 16 | Write data to the bus |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Read data from the bus |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bl_n | output | 2 | Byte lane selects, active low |

## Verification
The bench targets the following corner cases, and for each one says what a faulty design would show.

- **Partial writes on both widths.** A write with only some byte enables set is read back afterwards. A design that ignored the lane selects, or that swapped them, would return bytes that were meant to stay untouched.
- **Write with no enabled lane.** Such a write must still spend its full chip-select time while issuing no write strobe. A design that skipped the beat would show a shorter chip-select count. A design that pulsed the write enable anyway would show extra strobe cycles and corrupted contents.
- **Read and write timing sets.** Reads and writes are issued to banks whose two timing sets differ, and the extreme delay, wait and turnaround values of 15 are exercised. The chip-select time, the strobe time and the idle gap before the next chip select are all checked against the selected set. A design that mixed up the sets, or that counted a cycle too few, shows up in these numbers.
- **Beat order and addressing.** Checks on the stored beat layout and on the assembled read word catch reversed beat order, a wrong address step, and a read that picks up the undriven upper byte of an 8-bit bank.
- **Stalled response.** While the response is held, a response that changed its data or let a new request in would be caught.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int TIM_W = 4;

  typedef struct packed {
    logic [TIM_W-1:0] dly;
    logic [TIM_W-1:0] wt;
    logic [TIM_W-1:0] turn;
  } smc_tim_t;

  localparam int TIM_BITS = $bits(smc_tim_t);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_STRB  = 2'd2,
    ST_TURN  = 2'd3
  } smc_state_e;
endpackage

// File: rtl/smc_cfg_sel.sv
module smc_cfg_sel
  import smc_pkg::*;
#(
  parameter int NBANK = 4,
  localparam int BSW = $clog2(NBANK)
) (
  input  logic [NBANK*TIM_BITS-1:0] rd_tim_i,
  input  logic [NBANK*TIM_BITS-1:0] wr_tim_i,
  input  logic [NBANK-1:0]          bus16_i,
  input  logic [BSW-1:0]            bank_i,
  input  logic                      we_i,
  output smc_tim_t                  tim_o,
  output logic                      bus16_o
);
  smc_tim_t rd_arr [NBANK];
  smc_tim_t wr_arr [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_unpack
    assign rd_arr[g] = rd_tim_i[g*TIM_BITS +: TIM_BITS];
    assign wr_arr[g] = wr_tim_i[g*TIM_BITS +: TIM_BITS];
  end

  always_comb begin
    tim_o   = we_i ? wr_arr[bank_i] : rd_arr[bank_i];
    bus16_o = bus16_i[bank_i];
  end
endmodule

// File: rtl/smc_beat_seq.sv
module smc_beat_seq
  import smc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  smc_tim_t   tim_i,
  input  logic [1:0] last_beat_i,
  output smc_state_e state_o,
  output logic [1:0] beat_o,
  output logic       beat_end_o,
  output logic       done_o,
  output smc_tim_t   tim_o
);
  smc_state_e       state_q;
  logic [TIM_W-1:0] cnt_q;
  logic [1:0]       beat_q;
  logic [1:0]       last_q;
  smc_tim_t         tim_q;

  assign state_o    = state_q;
  assign beat_o     = beat_q;
  assign tim_o      = tim_q;
  assign beat_end_o = (state_q == ST_STRB) && (cnt_q == '0);
  assign done_o     = beat_end_o && (beat_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      last_q  <= '0;
      tim_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            tim_q  <= tim_i;
            last_q <= last_beat_i;
            beat_q <= '0;
            if (tim_i.dly == '0) begin
              state_q <= ST_STRB;
              cnt_q   <= tim_i.wt;
            end else begin
              state_q <= ST_SETUP;
              cnt_q   <= tim_i.dly - 1'b1;
            end
          end
        end
        ST_SETUP: begin
          if (cnt_q == '0) begin
            state_q <= ST_STRB;
            cnt_q   <= tim_q.wt;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_STRB: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (beat_q == last_q) begin
            if (tim_q.turn == '0) begin
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_TURN;
              cnt_q   <= tim_q.turn - 1'b1;
            end
          end else begin
            beat_q <= beat_q + 1'b1;
            if (tim_q.dly == '0) begin
              state_q <= ST_STRB;
              cnt_q   <= tim_q.wt;
            end else begin
              state_q <= ST_SETUP;
              cnt_q   <= tim_q.dly - 1'b1;
            end
          end
        end
        default: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
      endcase
    end
  end

  // R7: the beat index never runs past the last beat of the request
  a_r7_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    beat_q <= last_q);

  // R6: no request can start during a turnaround
  a_r6_turn_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TURN) |-> !start_i);

  // R4: the strobe stays on the same beat until its wait count runs out
  a_r4_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STRB && cnt_q != '0) |=> (state_q == ST_STRB && $stable(beat_q)));
endmodule

// File: rtl/smc_lane_pack.sv
module smc_lane_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        capture_i,
  input  logic        bus16_i,
  input  logic        we_i,
  input  logic [1:0]  beat_i,
  input  logic [31:0] wdata_i,
  input  logic [3:0]  be_i,
  input  logic [15:0] dq_i,
  output logic [15:0] dq_o,
  output logic [1:0]  bl_n_o,
  output logic        lane_en_o,
  output logic [31:0] rdata_o
);
  logic [31:0] asm_q;

  always_comb begin
    if (bus16_i) begin
      dq_o   = wdata_i[{beat_i[0], 4'b0000} +: 16];
      bl_n_o = we_i ? ~be_i[{beat_i[0], 1'b0} +: 2] : 2'b00;
    end else begin
      dq_o   = {8'h00, wdata_i[{beat_i, 3'b000} +: 8]};
      bl_n_o = {1'b1, we_i ? ~be_i[beat_i] : 1'b0};
    end
    lane_en_o = ~&bl_n_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q <= '0;
    end else if (clear_i) begin
      asm_q <= '0;
    end else if (capture_i) begin
      if (bus16_i) asm_q[{beat_i[0], 4'b0000} +: 16] <= dq_i;
      else         asm_q[{beat_i, 3'b000} +: 8]      <= dq_i[7:0];
    end
  end

  assign rdata_o = asm_q;
endmodule

// File: rtl/smc_bridge.sv
module smc_bridge
  import smc_pkg::*;
#(
  parameter int NBANK    = 4,
  parameter int AW       = 20,
  parameter int BANK_LSB = 24,
  localparam int BSW     = $clog2(NBANK),
  localparam int CFG_W   = NBANK * TIM_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  input  logic [CFG_W-1:0]  cfg_rd_tim,
  input  logic [CFG_W-1:0]  cfg_wr_tim,
  input  logic [NBANK-1:0]  cfg_bus16,
  output logic [NBANK-1:0]  mem_cs_n,
  output logic [AW-1:0]     mem_addr,
  output logic [15:0]       mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_i,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [1:0]        mem_bl_n
);
  smc_state_e      state;
  logic [1:0]      beat;
  logic            beat_end, done;
  smc_tim_t        sel_tim, act_tim;
  logic            sel_bus16;
  logic            accept, active;
  logic [BSW-1:0]  req_bank;

  logic [BSW-1:0]  bank_q;
  logic            we_q, bus16_q, rsp_q;
  logic [31:0]     wdata_q;
  logic [3:0]      be_q;
  logic [AW-1:0]   base_q;
  logic [1:0]      bl_n;
  logic            lane_en;
  logic [31:0]     rdata_asm;

  assign req_bank  = req_addr[BANK_LSB +: BSW];
  assign req_ready = (state == ST_IDLE) && !rsp_q;
  assign accept    = req_valid && req_ready;
  assign active    = (state == ST_SETUP) || (state == ST_STRB);

  smc_cfg_sel #(.NBANK(NBANK)) u_cfg_sel (
    .rd_tim_i (cfg_rd_tim),
    .wr_tim_i (cfg_wr_tim),
    .bus16_i  (cfg_bus16),
    .bank_i   (req_bank),
    .we_i     (req_we),
    .tim_o    (sel_tim),
    .bus16_o  (sel_bus16)
  );

  smc_beat_seq u_beat_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (accept),
    .tim_i       (sel_tim),
    .last_beat_i (sel_bus16 ? 2'd1 : 2'd3),
    .state_o     (state),
    .beat_o      (beat),
    .beat_end_o  (beat_end),
    .done_o      (done),
    .tim_o       (act_tim)
  );

  smc_lane_pack u_lane_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (accept),
    .capture_i (beat_end && !we_q),
    .bus16_i   (bus16_q),
    .we_i      (we_q),
    .beat_i    (beat),
    .wdata_i   (wdata_q),
    .be_i      (be_q),
    .dq_i      (mem_dq_i),
    .dq_o      (mem_dq_o),
    .bl_n_o    (bl_n),
    .lane_en_o (lane_en),
    .rdata_o   (rdata_asm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= '0;
      we_q    <= 1'b0;
      bus16_q <= 1'b0;
      wdata_q <= '0;
      be_q    <= '0;
      base_q  <= '0;
    end else if (accept) begin
      bank_q  <= req_bank;
      we_q    <= req_we;
      bus16_q <= sel_bus16;
      wdata_q <= req_wdata;
      be_q    <= req_be;
      base_q  <= sel_bus16 ? {req_addr[AW:2], 1'b0} : {req_addr[AW-1:2], 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rsp_q <= 1'b0;
    else if (done)               rsp_q <= 1'b1;
    else if (rsp_q && rsp_ready) rsp_q <= 1'b0;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_cs
    assign mem_cs_n[g] = !(active && (bank_q == BSW'(g)));
  end

  assign mem_addr  = base_q + AW'(beat);
  assign mem_oe_n  = !((state == ST_STRB) && !we_q);
  assign mem_we_n  = !((state == ST_STRB) && we_q && lane_en);
  assign mem_dq_oe = active && we_q;
  assign mem_bl_n  = active ? bl_n : 2'b11;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_asm;

  // ---------------- checks ----------------
  logic [4:0]       idle_cnt;
  logic [TIM_W-1:0] prev_turn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      prev_turn <= '0;
    end else begin
      if (&mem_cs_n) idle_cnt <= (idle_cnt == 5'd31) ? idle_cnt : idle_cnt + 1'b1;
      else           idle_cnt <= '0;
      if (done) prev_turn <= act_tim.turn;
    end
  end

  // R2: at most one chip select is active
  a_r2_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  // R4: a strobe only appears inside a chip select, and never both at once
  a_r4_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R8: the write strobe only appears while the data bus is driven
  a_r8_dq_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  // R11: a waiting response keeps its data
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R3: no request is taken while a response is pending
  a_r3_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R6: the idle gap before a new chip select covers the turnaround
  a_r6_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&mem_cs_n) |-> (idle_cnt >= 5'(prev_turn)));
endmodule

// File: tb/smc_bridge_tb_top.sv
module smc_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBANK = 4;
  localparam int AW = 20;

  // per bank nibbles {dly, wt, turn}, bank 0 in the low 12 bits (R5)
  localparam logic [47:0] RD_TIM = {12'hFFF, 12'h000, 12'h000, 12'h121};
  localparam logic [47:0] WR_TIM = {12'h30F, 12'h000, 12'h032, 12'h213};
  localparam logic [3:0]  BUS16  = 4'b0101;

  typedef struct packed {
    logic        we;
    logic [1:0]  bank;
    logic [7:0]  off;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 8'h10, 32'h11223344, 4'hF, 32'h0},
    '{1'b0, 2'd0, 8'h10, 32'h0,        4'h0, 32'h11223344},
    '{1'b1, 2'd0, 8'h10, 32'hAABBCCDD, 4'h5, 32'h0},
    '{1'b0, 2'd0, 8'h13, 32'h0,        4'h0, 32'h11BB33DD},
    '{1'b1, 2'd1, 8'h20, 32'hCAFEBABE, 4'hF, 32'h0},
    '{1'b0, 2'd1, 8'h20, 32'h0,        4'h0, 32'hCAFEBABE},
    '{1'b1, 2'd1, 8'h20, 32'h00000000, 4'h6, 32'h0},
    '{1'b0, 2'd1, 8'h20, 32'h0,        4'h0, 32'hCA0000BE},
    '{1'b1, 2'd2, 8'h04, 32'h13579BDF, 4'hF, 32'h0},
    '{1'b0, 2'd2, 8'h04, 32'h0,        4'h0, 32'h13579BDF},
    '{1'b0, 2'd0, 8'h10, 32'h0,        4'h0, 32'h11BB33DD},
    '{1'b1, 2'd3, 8'h08, 32'h0F1E2D3C, 4'hF, 32'h0},
    '{1'b0, 2'd3, 8'h08, 32'h0,        4'h0, 32'h0F1E2D3C},
    '{1'b1, 2'd3, 8'h08, 32'hFFFFFFFF, 4'h0, 32'h0},
    '{1'b0, 2'd3, 8'h08, 32'h0,        4'h0, 32'h0F1E2D3C}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0] req_be = '0;
  logic req_ready, rsp_valid, mem_dq_oe, mem_oe_n, mem_we_n;
  logic [31:0] rsp_rdata;
  logic [NBANK-1:0] mem_cs_n;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_dq_o, mem_dq_i;
  logic [1:0] mem_bl_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  smc_bridge #(.NBANK(NBANK), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cfg_rd_tim(RD_TIM), .cfg_wr_tim(WR_TIM), .cfg_bus16(BUS16),
    .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_bl_n(mem_bl_n)
  );

  // ---- external memory model: one array per bank ----
  logic [15:0] mem [NBANK][256];
  int sel_bank;

  always_comb begin
    sel_bank = 0;
    for (int b = 0; b < NBANK; b++) if (!mem_cs_n[b]) sel_bank = b;
  end

  always_comb begin
    if (!mem_oe_n && !(&mem_cs_n))
      mem_dq_i = BUS16[sel_bank] ? mem[sel_bank][mem_addr[7:0]]
                                 : {8'hA5, mem[sel_bank][mem_addr[7:0]][7:0]};
    else
      mem_dq_i = 16'h0000;
  end

  always @(posedge clk) begin
    if (!(&mem_cs_n) && !mem_we_n) begin
      if (!mem_bl_n[0]) mem[sel_bank][mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
      if (!mem_bl_n[1]) mem[sel_bank][mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
    end
  end

  // ---- bus monitor ----
  int cs_cnt = 0, stb_cnt = 0, idle_run = 0, last_gap = 0;
  bit prev_any = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!(&mem_cs_n)) begin
        if (!prev_any) begin
          last_gap = idle_run;
          idle_run = 0;
        end
        cs_cnt++;
      end else begin
        idle_run++;
      end
      prev_any = !(&mem_cs_n);
      if (!mem_oe_n || !mem_we_n) stb_cnt++;
    end
  end

  // ---- reporting ----
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input int act, input int lim);
    tests++;
    if (act < lim) begin
      fails++;
      $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
    end
  endtask

  function automatic logic [3:0] nib(input logic [47:0] t, input int b, input int sh);
    return t[b*12 + sh +: 4];
  endfunction

  int prev_turn = 0;

  task automatic run_vec(input vec_t v, input int idx);
    int cs0, st0, beats, dly, wt, trn, en_beats;
    logic [47:0] t;
    while (!req_ready) @(negedge clk);
    cs0 = cs_cnt;
    st0 = stb_cnt;
    req_valid = 1'b1;
    req_we    = v.we;
    req_addr  = {6'd0, v.bank, 16'd0, v.off};
    req_wdata = v.wdata;
    req_be    = v.be;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    t     = v.we ? WR_TIM : RD_TIM;
    dly   = int'(nib(t, int'(v.bank), 8));
    wt    = int'(nib(t, int'(v.bank), 4));
    trn   = int'(nib(t, int'(v.bank), 0));
    beats = BUS16[v.bank] ? 2 : 4;
    en_beats = 0;
    for (int k = 0; k < beats; k++) begin
      if (!v.we) en_beats++;
      else if (BUS16[v.bank] ? |v.be[2*k +: 2] : v.be[k]) en_beats++;
    end
    // R10 / R11: assembled read word, zero for writes
    chk($sformatf("R10 R11 vec%0d rdata", idx), rsp_rdata, v.exp);
    // R4 / R5: chip-select time from the selected timing set
    chk($sformatf("R4 R5 vec%0d cs cycles", idx), 32'(cs_cnt - cs0), 32'(beats * (dly + wt + 1)));
    // R9: strobe cycles only for beats with enabled lanes
    chk($sformatf("R9 R4 vec%0d strobe cycles", idx), 32'(stb_cnt - st0), 32'(en_beats * (wt + 1)));
    // R6: idle gap covers the previous turnaround
    if (idx > 0) chk_ge($sformatf("R6 vec%0d gap", idx), last_gap, prev_turn);
    prev_turn = trn;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    for (int b = 0; b < NBANK; b++)
      for (int a = 0; a < 256; a++) mem[b][a] = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R1 cs in reset", 32'(mem_cs_n), 32'hF);
    chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cs after reset", 32'(mem_cs_n), 32'hF);
    chk("R1 strobes after reset", {30'd0, mem_oe_n, mem_we_n}, 32'h3);
    chk("R1 dq_oe after reset", 32'(mem_dq_oe), 32'h0);
    chk("R1 req_ready after reset", 32'(req_ready), 32'h1);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R7 R8: beat placement in the external arrays
    chk("R7 R8 bank0 low half", 32'(mem[0][8]), 32'h33DD);
    chk("R7 R8 bank0 high half", 32'(mem[0][9]), 32'h11BB);
    chk("R7 bank2 beats", {mem[2][3], mem[2][2]}, 32'h13579BDF);
    chk("R7 R9 bank1 bytes",
        {mem[1][35][7:0], mem[1][34][7:0], mem[1][33][7:0], mem[1][32][7:0]}, 32'hCA0000BE);
    chk("R2 untouched bank2 slot", 32'(mem[2][8]), 32'h0);

    // R3 R11: stalled response holds and blocks new requests
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = {6'd0, 2'd2, 16'd0, 8'h04}; req_be = 4'h0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R11 rsp held", 32'(rsp_valid), 32'h1);
    chk("R11 rdata stable", rsp_rdata, 32'h13579BDF);
    chk("R3 ready low while pending", 32'(req_ready), 32'h0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R11 rsp cleared", 32'(rsp_valid), 32'h0);
    repeat (2) @(negedge clk);
    chk("R3 ready after drain", 32'(req_ready), 32'h1);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule